// File: doc/BRIEF.md
# Display Blink Timer

This block decides, cycle by cycle, whether an LED display's segment drivers are allowed to light. It keeps one free-running counter that the digit scan logic also uses. When blinking is turned on, the block derives alternating lit and dark half-periods from that counter. It offers two blink rates, and the first half-period after blinking starts can be either lit or dark.

The counter advances on a tick. The tick is either an internal timing pulse or a rising edge seen on an external clock pin, and the pin is synchronised into the system clock domain first. Several devices can share a load strobe. When the optional lock-step mode is set, a rising strobe edge clears every device's counter in the same cycle, so all of them blink together.

The tick rate is fixed at 2^TICK_LOG2 ticks per second. A fast half-period therefore lasts 2^(TICK_LOG2-1) ticks and a slow one lasts 2^TICK_LOG2 ticks. A small TICK_LOG2 keeps simulation short.

Top module: `blink_timer`

## Requirements
- R1: While `cfg_blink_en` is 0, `display_on` is 1. This includes the cycle in which blink enable falls.
- R2: With `cfg_blink_slow` = 0, lit and dark half-periods alternate, each lasting 2^(TICK_LOG2-1) ticks.
- R3: With `cfg_blink_slow` = 1, lit and dark half-periods alternate, each lasting 2^TICK_LOG2 ticks.
- R4: The first half-period after blinking starts, or after a lock-step clear, is lit when `cfg_start_on` = 1 and dark when it is 0. Whenever blinking is active and `scan_cnt` is 0, `display_on` equals `cfg_start_on`.
- R5: On the clock edge where `cfg_blink_en` is first seen high after being low, `scan_cnt` is set to 0. A tick on that same edge is discarded.
- R6: With `cfg_sync` = 1, `scan_cnt` reads 0 after the third rising clock edge that samples `load_strobe` high after it was low. This is one cycle after the two-stage synchronised edge is detected. Holding the strobe high does not clear the counter again.
- R7: With `cfg_sync` = 0, strobe edges leave `scan_cnt` unchanged.
- R8: With `cfg_ext_clk` = 1, `scan_cnt` advances by one for each rising edge of `ext_clk`. The increment arrives on the third clock edge after the pin is first sampled high. `int_tick` is ignored in this mode.
- R9: With `cfg_ext_clk` = 0, `scan_cnt` advances by one on each clock edge where `int_tick` is 1, and `ext_clk` is ignored.
- R10: `scan_cnt` is TICK_LOG2+1 bits wide and wraps from its maximum to 0.
- R11: Two instances that share the strobe, with `cfg_sync` = 1, have equal `scan_cnt` and `display_on` after a strobe edge, as long as they then receive the same ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| int_tick | input | 1 | Internal timing pulse, one clock wide |
| ext_clk | input | 1 | External clock pin, asynchronous |
| load_strobe | input | 1 | Load strobe pin, asynchronous |
| cfg_ext_clk | input | 1 | 1 selects the external clock pin as the tick source |
| cfg_blink_en | input | 1 | 1 enables blinking |
| cfg_blink_slow | input | 1 | 0 selects the fast half-period, 1 the slow one |
| cfg_sync | input | 1 | 1 lets a strobe rising edge clear the counter |
| cfg_start_on | input | 1 | Phase of the first half-period: 1 lit, 0 dark |
| display_on | output | 1 | Segment driver enable |
| scan_cnt | output | TICK_LOG2+1 | Shared scan and blink counter |

## Verification
On every cycle, the assertions check the following:
- The display stays lit while blinking is off.
- The counter steps by exactly one per selected tick, wraps correctly, and holds when there is no tick.
- Both clear sources, the blink-enable rise and the lock-step strobe edge, zero the counter on the next edge.
- A zero count with blinking active always shows the start phase.

Three things need the bench's directed scenarios:
- Whole half-period lengths for each rate and start phase.
- The exact latency from the raw strobe and external-clock pins through their synchronisers.
- Two instances fed different tick histories lining up after a shared strobe.

// File: rtl/blink_pkg.sv
package blink_pkg;

    // Configuration bits gathered into one word for the internal units.
    typedef struct packed {
        logic start_on;   // first half-period lit when set
        logic sync_on;    // strobe edge clears the shared counter
        logic slow;       // selects the long half-period
        logic blink_en;   // blinking active
        logic ext_sel;    // external pin supplies the tick
    } blink_cfg_t;

    typedef enum logic {
        PHASE_DARK = 1'b0,
        PHASE_LIT  = 1'b1
    } phase_e;

    // Counter width for a tick rate of 2**tick_log2 per second.
    // It covers one full slow period.
    function automatic int cnt_width(input int tick_log2);
        return tick_log2 + 1;
    endfunction

    // Index of the counter bit that flips once per half-period.
    function automatic int half_bit(input int tick_log2, input logic slow);
        return slow ? tick_log2 : tick_log2 - 1;
    endfunction

endpackage

// File: rtl/blink_edge_sync.sv
module blink_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    // chain[STAGES-1:0] synchronise the pin; chain[STAGES] holds the previous synchronised value.
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-1:0], din};
        end
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];

endmodule

// File: rtl/blink_tick_select.sv
module blink_tick_select #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic int_tick,
    input  logic ext_clk,
    input  logic ext_sel,
    output logic tick
);
    logic ext_rise;

    blink_edge_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (ext_clk),
        .rise (ext_rise)
    );

    assign tick = ext_sel ? ext_rise : int_tick;

endmodule

// File: rtl/blink_counter.sv
module blink_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/blink_phase.sv
module blink_phase
    import blink_pkg::*;
#(
    parameter int TICK_LOG2 = 3,
    localparam int CNT_W    = cnt_width(TICK_LOG2),
    localparam int FAST_BIT = half_bit(TICK_LOG2, 1'b0),
    localparam int SLOW_BIT = half_bit(TICK_LOG2, 1'b1)
) (
    input  logic             clk,
    input  logic             rst,
    input  blink_cfg_t       cfg,
    input  logic [CNT_W-1:0] cnt,
    output logic             en_q,
    output logic             en_rise,
    output logic             display_on
);
    logic   half_odd;
    phase_e phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= 1'b0;
        end else begin
            en_q <= cfg.blink_en;
        end
    end

    // A rising enable reloads the phase by clearing the shared counter.
    assign en_rise  = cfg.blink_en & ~en_q;

    assign half_odd = cfg.slow ? cnt[SLOW_BIT] : cnt[FAST_BIT];
    assign phase    = phase_e'(cfg.start_on ^ half_odd);

    // Blinking gates the display only once the reload edge has passed,
    // and releases it at once when blink enable drops.
    assign display_on = ~(cfg.blink_en & en_q) | (phase == PHASE_LIT);

endmodule

// File: rtl/blink_timer.sv
module blink_timer
    import blink_pkg::*;
#(
    parameter int TICK_LOG2   = 9,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = cnt_width(TICK_LOG2)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             int_tick,
    input  logic             ext_clk,
    input  logic             load_strobe,
    input  logic             cfg_ext_clk,
    input  logic             cfg_blink_en,
    input  logic             cfg_blink_slow,
    input  logic             cfg_sync,
    input  logic             cfg_start_on,
    output logic             display_on,
    output logic [CNT_W-1:0] scan_cnt
);
    blink_cfg_t cfg;
    logic       tick_sel;
    logic       strobe_rise;
    logic       en_q;
    logic       en_rise;
    logic       cnt_clr;

    always_comb begin
        cfg.start_on = cfg_start_on;
        cfg.sync_on  = cfg_sync;
        cfg.slow     = cfg_blink_slow;
        cfg.blink_en = cfg_blink_en;
        cfg.ext_sel  = cfg_ext_clk;
    end

    blink_tick_select #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
        .clk      (clk),
        .rst      (rst),
        .int_tick (int_tick),
        .ext_clk  (ext_clk),
        .ext_sel  (cfg.ext_sel),
        .tick     (tick_sel)
    );

    blink_edge_sync #(.STAGES(SYNC_STAGES)) u_strobe_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (load_strobe),
        .rise (strobe_rise)
    );

    assign cnt_clr = (cfg.sync_on & strobe_rise) | en_rise;

    blink_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .clr  (cnt_clr),
        .tick (tick_sel),
        .cnt  (scan_cnt)
    );

    blink_phase #(.TICK_LOG2(TICK_LOG2)) u_phase (
        .clk        (clk),
        .rst        (rst),
        .cfg        (cfg),
        .cnt        (scan_cnt),
        .en_q       (en_q),
        .en_rise    (en_rise),
        .display_on (display_on)
    );

endmodule

// File: rtl/blink_timer_checker.sv
module blink_timer_checker #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_blink_en,
    input logic             cfg_sync,
    input logic             cfg_start_on,
    input logic             display_on,
    input logic             en_q,
    input logic             strobe_rise,
    input logic             tick_sel,
    input logic             cnt_clr,
    input logic [CNT_W-1:0] scan_cnt
);
    p_steady_on_r1: assert property (@(posedge clk) disable iff (rst)
        !cfg_blink_en |-> display_on);

    p_first_phase_r4: assert property (@(posedge clk) disable iff (rst)
        (cfg_blink_en && en_q && scan_cnt == '0) |-> (display_on == cfg_start_on));

    p_enable_clear_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_blink_en) |=> (scan_cnt == '0));

    p_sync_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (cfg_sync && strobe_rise) |=> (scan_cnt == '0));

    p_strobe_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (!cfg_sync && !tick_sel && !(cfg_blink_en && !en_q)) |=> $stable(scan_cnt));

    // One step per selected tick, wrapping modulo 2**CNT_W (R10).
    p_tick_step_r9: assert property (@(posedge clk) disable iff (rst)
        (!cnt_clr && tick_sel) |=> (scan_cnt == CNT_W'($past(scan_cnt) + 1'b1)));

    p_tick_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!cnt_clr && !tick_sel) |=> $stable(scan_cnt));

endmodule

bind blink_timer blink_timer_checker #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_blink_en (cfg_blink_en),
    .cfg_sync     (cfg_sync),
    .cfg_start_on (cfg_start_on),
    .display_on   (display_on),
    .en_q         (en_q),
    .strobe_rise  (strobe_rise),
    .tick_sel     (tick_sel),
    .cnt_clr      (cnt_clr),
    .scan_cnt     (scan_cnt)
);

// File: tb/blink_timer_bench.sv
`timescale 1ns/1ps
module blink_timer_bench;
    localparam int TL  = 3;
    localparam int CW  = TL + 1;
    localparam int MOD = 1 << CW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_a = 1'b0, tick_b = 1'b0, ext_clk = 1'b0, strobe = 1'b0;
    logic c_ext = 1'b0, c_en = 1'b0, c_slow = 1'b0, c_sync = 1'b0, c_start = 1'b0;
    logic disp_a, disp_b;
    logic [CW-1:0] cnt_a, cnt_b;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    blink_timer #(.TICK_LOG2(TL)) u_blink_timer (
        .clk(clk), .rst(rst), .int_tick(tick_a), .ext_clk(ext_clk), .load_strobe(strobe),
        .cfg_ext_clk(c_ext), .cfg_blink_en(c_en), .cfg_blink_slow(c_slow),
        .cfg_sync(c_sync), .cfg_start_on(c_start), .display_on(disp_a), .scan_cnt(cnt_a));

    blink_timer #(.TICK_LOG2(TL)) u_peer (
        .clk(clk), .rst(rst), .int_tick(tick_b), .ext_clk(ext_clk), .load_strobe(strobe),
        .cfg_ext_clk(c_ext), .cfg_blink_en(c_en), .cfg_blink_slow(c_slow),
        .cfg_sync(c_sync), .cfg_start_on(c_start), .display_on(disp_b), .scan_cnt(cnt_b));

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        repeat (3) step();
        @(negedge clk);
        rst = 1'b0;
        step();
        check("R10 reset count", int'(cnt_a), 0);
        check("R1 reset display", int'(disp_a), 1);
    endtask

    task automatic t_disabled();
        @(negedge clk);
        c_en = 1'b0;
        tick_a = 1'b1;
        for (int k = 0; k < 20; k++) begin
            step();
            check("R1 steady lit", int'(disp_a), 1);
        end
        check("R10 wrap", int'(cnt_a), 20 % MOD);
        @(negedge clk);
        tick_a = 1'b0;
    endtask

    task automatic t_int();
        int v;
        @(negedge clk);
        c_ext = 1'b0;
        v = int'(cnt_a);
        for (int p = 0; p < 4; p++) begin
            @(negedge clk); ext_clk = 1'b1; step(); step();
            @(negedge clk); ext_clk = 1'b0; step(); step();
        end
        check("R9 ext pin ignored", int'(cnt_a), v);
        for (int p = 0; p < 3; p++) begin
            @(negedge clk); tick_a = 1'b1; step();
            @(negedge clk); tick_a = 1'b0; step();
        end
        check("R9 int ticks counted", int'(cnt_a), (v + 3) % MOD);
    endtask

    task automatic t_ext();
        int v;
        @(negedge clk);
        c_ext = 1'b1;
        tick_a = 1'b1;
        v = int'(cnt_a);
        @(negedge clk); ext_clk = 1'b1;
        step();
        check("R8 no step on first sample", int'(cnt_a), v);
        step();
        check("R8 no step on second sample", int'(cnt_a), v);
        @(negedge clk); ext_clk = 1'b0;
        step();
        check("R8 step on third edge", int'(cnt_a), (v + 1) % MOD);
        step();
        for (int p = 0; p < 4; p++) begin
            @(negedge clk); ext_clk = 1'b1; step(); step();
            @(negedge clk); ext_clk = 1'b0; step(); step();
        end
        check("R8 one step per pin edge", int'(cnt_a), (v + 5) % MOD);
        repeat (6) step();
        check("R8 int tick ignored", int'(cnt_a), (v + 5) % MOD);
        @(negedge clk);
        c_ext = 1'b0;
        tick_a = 1'b0;
    endtask

    task automatic t_phase(input logic slow, input logic start);
        int h;
        string req;
        h = slow ? (1 << TL) : (1 << (TL - 1));
        req = slow ? "R3 slow phase" : "R2 fast phase";
        @(negedge clk);
        c_en = 1'b0; c_sync = 1'b0; c_ext = 1'b0; tick_a = 1'b0;
        @(negedge clk);
        c_slow = slow; c_start = start; c_en = 1'b1; tick_a = 1'b1;
        step();
        check("R5 enable clears count", int'(cnt_a), 0);
        check("R4 start phase", int'(disp_a), int'(start));
        for (int k = 1; k < 4 * h; k++) begin
            step();
            check(req, int'(disp_a), int'(start) ^ ((k / h) % 2));
        end
        @(negedge clk);
        c_en = 1'b0;
        #1;
        check("R1 lit on disable", int'(disp_a), 1);
        tick_a = 1'b0;
    endtask

    task automatic t_sync_clear();
        int v;
        @(negedge clk);
        c_en = 1'b0; c_sync = 1'b1; c_slow = 1'b0; c_start = 1'b0; strobe = 1'b0; tick_a = 1'b0;
        @(negedge clk);
        c_en = 1'b1; tick_a = 1'b1;
        repeat (5) step();
        @(negedge clk);
        tick_a = 1'b0;
        v = int'(cnt_a);
        check("R2 lit before clear", int'(disp_a), 1);
        strobe = 1'b1;
        step();
        check("R6 held edge 1", int'(cnt_a), v);
        step();
        check("R6 held edge 2", int'(cnt_a), v);
        step();
        check("R6 cleared edge 3", int'(cnt_a), 0);
        check("R4 phase after clear", int'(disp_a), 0);
        @(negedge clk);
        tick_a = 1'b1;
        repeat (3) step();
        check("R6 no reclear while high", int'(cnt_a), 3);
        @(negedge clk);
        tick_a = 1'b0;
        strobe = 1'b0;
    endtask

    task automatic t_sync_off();
        int v;
        @(negedge clk);
        c_sync = 1'b0;
        strobe = 1'b0;
        repeat (4) step();
        @(negedge clk);
        v = int'(cnt_a);
        strobe = 1'b1;
        repeat (6) step();
        check("R7 strobe ignored", int'(cnt_a), v);
        @(negedge clk);
        strobe = 1'b0;
    endtask

    task automatic t_align();
        @(negedge clk);
        c_ext = 1'b0; c_en = 1'b1; c_sync = 1'b1; c_slow = 1'b0; c_start = 1'b1;
        strobe = 1'b0; tick_a = 1'b0; tick_b = 1'b1;
        repeat (5) step();
        @(negedge clk);
        tick_b = 1'b0;
        strobe = 1'b1;
        repeat (3) step();
        check("R11 main cleared", int'(cnt_a), 0);
        check("R11 peer cleared", int'(cnt_b), 0);
        @(negedge clk);
        tick_a = 1'b1; tick_b = 1'b1;
        for (int k = 0; k < 20; k++) begin
            step();
            check("R11 count aligned", int'(cnt_a), int'(cnt_b));
            check("R11 display aligned", int'(disp_a), int'(disp_b));
        end
        @(negedge clk);
        tick_a = 1'b0; tick_b = 1'b0; strobe = 1'b0;
    endtask

    initial begin
        t_reset();
        t_disabled();
        t_int();
        t_ext();
        t_phase(1'b0, 1'b1);
        t_phase(1'b0, 1'b0);
        t_phase(1'b1, 1'b1);
        t_phase(1'b1, 1'b0);
        t_sync_clear();
        t_sync_off();
        t_align();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule